// File: doc/BRIEF.md
# Byte-register I2C master controller

This block is a single-master I2C controller for a small byte-wide register port. A control register enables the block and selects host mode, direction and the acknowledge policy for received bytes. A status register reports whether the bus is held, whether the last byte has completed, and what acknowledge the target returned. A data register is written to send a byte and read to collect a received byte. SCL and SDA are driven as open-drain enables: a 1 on an enable pulls the line low.

Transfers are started by register side effects. Setting the host-mode bit while the block is enabled issues a START condition. In transmit direction, each data write shifts one byte out, the first being the target address and direction bit. In receive direction, each data read returns the byte last received and launches the next byte, so the first read after the direction change returns stale data. Clearing the host-mode bit issues a STOP. For the final received byte, software clears host mode first and then reads the data register, which returns the byte without starting another. The bit rate is the system clock divided by four times the divider parameter. A target that holds SCL low stalls the bit timing until SCL goes high.

Top module: `i2ch_top`

## Requirements
- R1: After reset, the control register (address 0), status register (address 1) and data register (address 2) all read 0x00, both line enables are 0 and irq is 0.
- R2: Writing the control register with enable (bit 7) and host mode (bit 5) both 1, while host mode was 0, makes the busy bit (status bit 5) read 1 on the next cycle and produces one START (SDA falling while SCL is high).
- R3: With enable, host mode and transmit (bit 4) set, a data register write sends the byte MSB first; the first byte after START is the 7-bit address shifted left by one, with bit 0 as direction (1 = read, 0 = write).
- R4: The done flag (status bit 1) becomes 1 when a byte and its acknowledge bit complete; a status write with bit 1 equal to 0 clears it, and a status write with bit 1 equal to 1 leaves it unchanged.
- R5: Status bit 0 holds the SDA level sampled in the ninth clock of the last transmitted byte: 0 when the target acknowledged, 1 when it did not.
- R6: irq equals 1 exactly while the done flag and the interrupt-enable bit (control bit 6) are both 1.
- R7: With enable and host mode set and transmit clear, a data register read returns the last received byte and launches reception of the next byte; the first such read returns stale data.
- R8: For a received byte, the acknowledge bit is taken from control bit 3 at the moment the byte is launched: 0 drives an ACK (SDA low), 1 leaves SDA released (NACK).
- R9: Clearing host mode while busy produces a STOP (SDA rising while SCL is high) after any pending byte, and the busy bit then reads 0.
- R10: A data register read while host mode is 0 returns the received byte but starts no bus activity and leaves the done flag at 0.
- R11: SDA changes while SCL is released only as part of a START or STOP.
- R12: A data register write while enable or host mode is 0 causes no bus activity and does not set the done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data register read has side effects) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt: done flag and interrupt enable both set |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions take for granted that the target changes SDA only while SCL is low, that no second master shares the lines, and that software waits for the done flag before it touches the data register again. The bench keeps to this: its target model changes SDA only after it sees SCL fall, and every data access follows a poll of the status register that has found the done flag set or the bus idle. The divider is kept at four or more, so the two-stage input synchronisers settle within one quarter-bit.

// File: rtl/i2ch_pkg.sv
package i2ch_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // register select
    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_STS = 2'd1;
    localparam logic [1:0] A_DAT = 2'd2;

    // control bits
    localparam int CTL_EN  = 7;
    localparam int CTL_IE  = 6;
    localparam int CTL_MST = 5;
    localparam int CTL_TX  = 4;
    localparam int CTL_NAK = 3;

    // status bits
    localparam int ST_BUSY = 5;
    localparam int ST_DONE = 1;
    localparam int ST_RXAK = 0;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_START,
        ENG_HOLD,
        ENG_BITS,
        ENG_STOP
    } eng_state_e;

    typedef struct packed {
        eng_state_e        st;
        logic [1:0]        ph;
        logic [CNT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              tx;
        logic              nak;
        logic              ack;
        logic              scl_low;
        logic              sda_low;
        logic [1:0]        scl_sy;
        logic [1:0]        sda_sy;
    } eng_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctl;
        logic              busy;
        logic              done;
        logic              rxak;
        logic [BYTE_W-1:0] rxd;
        logic [BYTE_W-1:0] txd;
        logic              p_start;
        logic              p_byte;
        logic              p_stop;
        logic              b_tx;
        logic              b_nak;
    } regs_t;

endpackage

// File: rtl/i2ch_tick.sv
module i2ch_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end else if (!hold) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2ch_engine.sv
module i2ch_engine
    import i2ch_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_byte,
    input  logic              req_stop,
    input  logic              byte_tx,
    input  logic              byte_nak,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              take_start,
    output logic              take_byte,
    output logic              take_stop,
    output logic              byte_done,
    output logic              stop_done,
    output logic              cur_tx,
    output logic              rx_ack,
    output logic [BYTE_W-1:0] rx_data,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_t r_q, r_d;
    logic tick, hold, restart, scl_s, sda_s;

    assign scl_s   = r_q.scl_sy[1];
    assign sda_s   = r_q.sda_sy[1];
    assign hold    = !r_q.scl_low && !scl_s;   // target stretching SCL
    assign restart = take_start || take_byte || take_stop;

    i2ch_tick #(.DIV(DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .hold   (hold),
        .tick   (tick)
    );

    always_comb begin
        r_d        = r_q;
        take_start = 1'b0;
        take_byte  = 1'b0;
        take_stop  = 1'b0;
        byte_done  = 1'b0;
        stop_done  = 1'b0;
        r_d.scl_sy = {r_q.scl_sy[0], scl_in};
        r_d.sda_sy = {r_q.sda_sy[0], sda_in};

        unique case (r_q.st)
            ENG_IDLE: begin
                if (req_start) begin
                    take_start  = 1'b1;
                    r_d.st      = ENG_START;
                    r_d.ph      = 2'd0;
                    r_d.scl_low = 1'b0;
                    r_d.sda_low = 1'b0;
                end
            end
            ENG_START: begin
                if (tick) begin
                    if (r_q.ph == 2'd0) begin
                        r_d.sda_low = 1'b1;
                        r_d.ph      = 2'd1;
                    end else begin
                        r_d.scl_low = 1'b1;
                        r_d.st      = ENG_HOLD;
                    end
                end
            end
            ENG_HOLD: begin
                if (req_byte) begin
                    take_byte = 1'b1;
                    r_d.st    = ENG_BITS;
                    r_d.ph    = 2'd0;
                    r_d.bitn  = '0;
                    r_d.sh    = byte_data;
                    r_d.tx    = byte_tx;
                    r_d.nak   = byte_nak;
                end else if (req_stop) begin
                    take_stop   = 1'b1;
                    r_d.st      = ENG_STOP;
                    r_d.ph      = 2'd0;
                    r_d.sda_low = 1'b1;
                end
            end
            ENG_BITS: begin
                if (tick) begin
                    unique case (r_q.ph)
                        2'd0: begin
                            if (r_q.bitn == LAST_BIT)
                                r_d.sda_low = !r_q.tx && !r_q.nak;
                            else
                                r_d.sda_low = r_q.tx && !r_q.sh[BYTE_W-1];
                            r_d.ph = 2'd1;
                        end
                        2'd1: begin
                            r_d.scl_low = 1'b0;
                            r_d.ph      = 2'd2;
                        end
                        2'd2: begin
                            if (r_q.bitn == LAST_BIT) begin
                                if (r_q.tx) r_d.ack = sda_s;
                            end else begin
                                r_d.sh = {r_q.sh[BYTE_W-2:0], sda_s};
                            end
                            r_d.ph = 2'd3;
                        end
                        default: begin
                            r_d.scl_low = 1'b1;
                            if (r_q.bitn == LAST_BIT) begin
                                r_d.st    = ENG_HOLD;
                                byte_done = 1'b1;
                            end else begin
                                r_d.bitn = r_q.bitn + 1'b1;
                                r_d.ph   = 2'd0;
                            end
                        end
                    endcase
                end
            end
            ENG_STOP: begin
                if (tick) begin
                    if (r_q.ph == 2'd0) begin
                        r_d.scl_low = 1'b0;
                        r_d.ph      = 2'd1;
                    end else begin
                        r_d.sda_low = 1'b0;
                        r_d.st      = ENG_IDLE;
                        stop_done   = 1'b1;
                    end
                end
            end
            default: r_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ENG_IDLE;
            r_q.scl_sy  <= 2'b11;
            r_q.sda_sy  <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe  = r_q.scl_low;
    assign sda_oe  = r_q.sda_low;
    assign rx_data = r_q.sh;
    assign rx_ack  = r_q.ack;
    assign cur_tx  = r_q.tx;

    // R11: with SCL released on both sides of an edge, SDA only moves in START/STOP
    a_r11_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.scl_low && !$past(r_q.scl_low) && (r_q.sda_low != $past(r_q.sda_low)))
        |-> ($past(r_q.st) == ENG_START || $past(r_q.st) == ENG_STOP));

    // R3: a byte shift only begins from the SCL-held-low wait state
    a_r3_byte_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ENG_BITS && $past(r_q.st) != ENG_BITS) |-> ($past(r_q.st) == ENG_HOLD));
endmodule

// File: rtl/i2ch_top.sv
module i2ch_top
    import i2ch_pkg::*;
#(
    parameter int CLK_DIV = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    regs_t r_q, r_d;

    logic take_start, take_byte, take_stop, byte_done, stop_done;
    logic cur_tx, eng_ack;
    logic [BYTE_W-1:0] eng_rx;
    logic wr_ctl, wr_sts, wr_dat, rd_dat, can_run;

    i2ch_engine #(.DIV(CLK_DIV)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (r_q.p_start),
        .req_byte  (r_q.p_byte),
        .req_stop  (r_q.p_stop),
        .byte_tx   (r_q.b_tx),
        .byte_nak  (r_q.b_nak),
        .byte_data (r_q.txd),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .take_start(take_start),
        .take_byte (take_byte),
        .take_stop (take_stop),
        .byte_done (byte_done),
        .stop_done (stop_done),
        .cur_tx    (cur_tx),
        .rx_ack    (eng_ack),
        .rx_data   (eng_rx),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    assign wr_ctl  = bus_wr && (bus_addr == A_CTL);
    assign wr_sts  = bus_wr && (bus_addr == A_STS);
    assign wr_dat  = bus_wr && (bus_addr == A_DAT);
    assign rd_dat  = bus_rd && (bus_addr == A_DAT);
    assign can_run = r_q.ctl[CTL_EN] && r_q.ctl[CTL_MST] && r_q.busy;

    always_comb begin
        r_d = r_q;

        if (take_start) r_d.p_start = 1'b0;
        if (take_byte)  r_d.p_byte  = 1'b0;
        if (take_stop)  r_d.p_stop  = 1'b0;
        if (stop_done)  r_d.busy    = 1'b0;

        if (wr_sts) r_d.done = r_q.done & bus_wdata[ST_DONE];

        if (byte_done) begin
            r_d.done = 1'b1;
            r_d.rxak = eng_ack;
            if (!cur_tx) r_d.rxd = eng_rx;
        end

        if (wr_ctl) begin
            r_d.ctl = {bus_wdata[7:3], 3'b000};
            if (bus_wdata[CTL_EN] && bus_wdata[CTL_MST] && !r_q.ctl[CTL_MST] && !r_q.busy) begin
                r_d.p_start = 1'b1;
                r_d.busy    = 1'b1;
            end
            if (r_q.ctl[CTL_MST] && !bus_wdata[CTL_MST] && r_q.busy)
                r_d.p_stop = 1'b1;
        end

        if (wr_dat && can_run && r_q.ctl[CTL_TX]) begin
            r_d.p_byte = 1'b1;
            r_d.txd    = bus_wdata;
            r_d.b_tx   = 1'b1;
            r_d.b_nak  = 1'b0;
        end

        if (rd_dat && can_run && !r_q.ctl[CTL_TX]) begin
            r_d.p_byte = 1'b1;
            r_d.b_tx   = 1'b0;
            r_d.b_nak  = r_q.ctl[CTL_NAK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTL:   bus_rdata = r_q.ctl;
            A_STS:   bus_rdata = {2'b00, r_q.busy, 3'b000, r_q.done, r_q.rxak};
            A_DAT:   bus_rdata = r_q.rxd;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq = r_q.done && r_q.ctl[CTL_IE];

    // R2: busy only rises after a control write that enables host mode
    a_r2_busy_from_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.busy) |-> $past(wr_ctl && bus_wdata[CTL_EN] && bus_wdata[CTL_MST]));

    // R4: the done flag is raised only by a completed byte in the engine
    a_r4_done_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> $past(byte_done));

    // R9: busy drops only when the engine finishes a STOP
    a_r9_busy_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.busy) |-> $past(stop_done));

    // R10, R12: a byte is only queued while enabled and in host mode
    a_r10_launch_needs_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.p_byte) |-> $past(r_q.ctl[CTL_MST] && r_q.ctl[CTL_EN]));
endmodule

// File: tb/i2ch_top_tb_top.sv
module i2ch_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam logic [6:0] SLV_ADDR = 7'h2C;
    localparam int NWR = 4;
    localparam logic [7:0] WR_VEC [NWR] = '{8'h3C, 8'h81, 8'h00, 8'hFF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic irq, scl_oe, sda_oe;
    logic scl_line, sda_line;
    logic s_drv = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || s_drv);

    i2ch_top #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // bus monitor
    int start_cnt = 0, stop_cnt = 0, rise_cnt = 0;
    logic m_pscl = 1'b1, m_psda = 1'b1;
    always @(negedge clk) begin
        if (scl_line && m_pscl && m_psda && !sda_line) start_cnt++;
        if (scl_line && m_pscl && !m_psda && sda_line) stop_cnt++;
        if (scl_line && !m_pscl) rise_cnt++;
        m_pscl = scl_line;
        m_psda = sda_line;
    end

    // target model
    logic nack_data = 1'b0;
    logic s_pscl, s_psda, s_act, s_addrph, s_match, s_rw, s_send, s_end;
    logic [3:0] s_cnt, s_wcnt;
    logic [7:0] s_sh, s_txb, s_rcnt, nxt_txb;
    logic [7:0] s_mem [8];
    int s_mack, s_mnak;
    assign nxt_txb = 8'hA5 + s_rcnt;

    always @(negedge clk) begin
        if (!rst_n) begin
            s_pscl <= 1'b1; s_psda <= 1'b1; s_act <= 1'b0; s_addrph <= 1'b0;
            s_match <= 1'b0; s_rw <= 1'b0; s_send <= 1'b0; s_end <= 1'b0;
            s_cnt <= '0; s_wcnt <= '0; s_sh <= '0; s_txb <= '0; s_rcnt <= '0;
            s_drv <= 1'b0; s_mack <= 0; s_mnak <= 0;
        end else begin
            s_pscl <= scl_line;
            s_psda <= sda_line;
            if (scl_line && s_pscl && s_psda && !sda_line) begin
                s_act <= 1'b1; s_cnt <= '0; s_addrph <= 1'b1; s_drv <= 1'b0;
                s_send <= 1'b0; s_end <= 1'b0; s_match <= 1'b0;
            end else if (scl_line && s_pscl && !s_psda && sda_line) begin
                s_act <= 1'b0; s_drv <= 1'b0; s_send <= 1'b0;
            end else if (s_act && scl_line && !s_pscl) begin
                if (s_cnt < 4'd8) s_sh <= {s_sh[6:0], sda_line};
                else if (s_send) begin
                    if (sda_line) begin s_mnak <= s_mnak + 1; s_end <= 1'b1; end
                    else s_mack <= s_mack + 1;
                end
                s_cnt <= s_cnt + 1'b1;
            end else if (s_act && !scl_line && s_pscl) begin
                if (s_cnt == 4'd8) begin
                    if (s_send) s_drv <= 1'b0;
                    else if (s_addrph) begin
                        s_match  <= (s_sh[7:1] == SLV_ADDR);
                        s_rw     <= s_sh[0];
                        s_drv    <= (s_sh[7:1] == SLV_ADDR);
                        s_addrph <= 1'b0;
                    end else if (s_match) begin
                        s_mem[s_wcnt[2:0]] <= s_sh;
                        s_wcnt <= s_wcnt + 1'b1;
                        s_drv  <= !nack_data;
                    end
                end else if (s_cnt == 4'd9) begin
                    s_cnt <= '0;
                    s_drv <= 1'b0;
                    if (s_match && s_rw && !s_end) begin
                        s_send <= 1'b1; s_txb <= nxt_txb; s_rcnt <= s_rcnt + 1'b1;
                        s_drv  <= !nxt_txb[7];
                    end else s_send <= 1'b0;
                end else if (s_send && s_cnt >= 4'd1 && s_cnt <= 4'd7) begin
                    s_drv <= !s_txb[7 - s_cnt];
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [7:0] st;
        int n = 0;
        st = 8'h00;
        while (!st[1] && n < 1000) begin reg_rd(2'd1, st); n++; end
        chk(req, {31'd0, st[1]}, 32'd1);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] st;
        int n = 0;
        st = 8'hFF;
        while (st[5] && n < 1000) begin reg_rd(2'd1, st); n++; end
        chk(req, {31'd0, st[5]}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int sc, rc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(2'd0, v); chk("R1 ctl", v, 8'h00);
        reg_rd(2'd1, v); chk("R1 sts", v, 8'h00);
        reg_rd(2'd2, v); chk("R1 dat", v, 8'h00);
        chk("R1 lines", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R12 data write without host mode
        sc = start_cnt; rc = rise_cnt;
        reg_wr(2'd2, 8'h55);
        reg_wr(2'd0, 8'h90);
        reg_wr(2'd2, 8'h66);
        repeat (200) @(negedge clk);
        chk("R12 no scl", rise_cnt, rc);
        chk("R12 no start", start_cnt, sc);
        reg_rd(2'd1, v); chk("R12 done", {31'd0, v[1]}, 32'd0);

        // R2 start
        sc = start_cnt;
        reg_wr(2'd0, 8'hF0);
        reg_rd(2'd1, v); chk("R2 busy", {31'd0, v[5]}, 32'd1);
        // R3 address write
        reg_wr(2'd2, {SLV_ADDR, 1'b0});
        wait_done("R4 addr done");
        chk("R2 start seen", start_cnt, sc + 1);
        reg_rd(2'd1, v); chk("R5 addr ack", {31'd0, v[0]}, 32'd0);
        chk("R6 irq on", {31'd0, irq}, 32'd1);
        reg_wr(2'd1, 8'h02);
        reg_rd(2'd1, v); chk("R4 write1 keeps", {31'd0, v[1]}, 32'd1);
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd1, v); chk("R4 write0 clears", {31'd0, v[1]}, 32'd0);
        chk("R6 irq off", {31'd0, irq}, 32'd0);

        // R3 vector table of write bytes
        for (int i = 0; i < NWR; i++) begin
            reg_wr(2'd2, WR_VEC[i]);
            wait_done("R4 byte done");
            reg_rd(2'd1, v); chk("R5 data ack", {31'd0, v[0]}, 32'd0);
            reg_wr(2'd1, 8'h00);
        end
        for (int i = 0; i < NWR; i++) chk("R3 target byte", s_mem[i], WR_VEC[i]);
        chk("R3 target count", s_wcnt, NWR);

        // R5 target refusing data
        nack_data = 1'b1;
        reg_wr(2'd2, 8'h12);
        wait_done("R4 nack byte done");
        reg_rd(2'd1, v); chk("R5 data nack", {31'd0, v[0]}, 32'd1);
        reg_wr(2'd1, 8'h00);
        nack_data = 1'b0;

        // R9 stop
        sc = stop_cnt;
        reg_wr(2'd0, 8'hC0);
        wait_idle("R9 busy clears");
        chk("R9 stop seen", stop_cnt, sc + 1);

        // R5 wrong address
        reg_wr(2'd0, 8'hF0);
        reg_wr(2'd2, {7'h11, 1'b0});
        wait_done("R4 bad addr done");
        reg_rd(2'd1, v); chk("R5 addr nack", {31'd0, v[0]}, 32'd1);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'hC0);
        wait_idle("R9 busy clears 2");

        // R7 R8 R10 read three bytes
        reg_wr(2'd0, 8'hF0);
        reg_wr(2'd2, {SLV_ADDR, 1'b1});
        wait_done("R4 read addr done");
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'hE0);
        reg_rd(2'd2, v);                       // stale read, launches byte 0
        wait_done("R7 byte0 done");
        reg_wr(2'd1, 8'h00);
        reg_rd(2'd2, v); chk("R7 byte0", v, 8'hA5);
        wait_done("R7 byte1 done");
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'hE8);                   // next launched byte gets NACK
        reg_rd(2'd2, v); chk("R7 byte1", v, 8'hA6);
        wait_done("R7 byte2 done");
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'hC8);                   // leave host mode: STOP
        reg_rd(2'd2, v); chk("R10 last byte", v, 8'hA7);
        wait_idle("R9 busy clears 3");
        rc = rise_cnt;
        repeat (300) @(negedge clk);
        reg_rd(2'd1, v); chk("R10 no done", {31'd0, v[1]}, 32'd0);
        chk("R10 no scl", rise_cnt, rc);
        chk("R8 acks seen", s_mack, 2);
        chk("R8 nack seen", s_mnak, 1);
        chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule